// File: doc/BRIEF.md
# Multi-vector FMA issue sequencer

This block takes one 32-bit multi-vector fused multiply-add instruction word and turns it into a short burst of access requests, one per clock. It checks the word for legality and works out the group size, which is two or four vectors. For each vector of the group it presents the first-source vector register, the shared second-source register, the accumulator-array row, the element width and the number of elements per vector. The floating-point arithmetic and the storage sit downstream and take these requests as they are issued.

The caller supplies the current vector length and two feature enables, one for double precision and one for half precision. It also supplies the value of the index register. The block names that register combinationally on `idxRegSel`, and its value must be presented in the same cycle as the strobe. An illegal word does not issue any step. Instead it raises a single-cycle undefined flag.

Top module: `mvfma_issue_seq`

## Requirements
- R1: A strobed word with a mismatch in any fixed bit raises `undefFlag` for exactly one cycle, starting the cycle after acceptance, and issues no step. The fixed bits are [31:23]=110000010, [21]=1, [15]=0, [12:11]=11 and [4:3]=00.
- R2: Bit [10] selects the form: 0 is single/double and 1 is half precision. Bit [22] is the size bit sz. The word is undefined in three cases: sz=1 in the single/double form while `dblEn` is 0; the half form while `halfEn` is 0; the half form with sz=1. R1 timing applies.
- R3: A legal word issues exactly nreg steps on consecutive cycles. The first step comes one cycle after acceptance. nreg is 2 when bit [20] is 0 and 4 when it is 1. `stepDone` is high only on the last step.
- R4: On step r, `srcN` equals (Zn + r) mod 32, where Zn is bits [9:5].
- R5: `srcM` equals Zm (bits [19:16], range 0 to 15) and holds this value on every step.
- R6: The first row equals (index value + offset) mod stride. The offset is bits [2:0]. The stride is (VL/8)/nreg, and every row stays below VL/8.
- R7: Each later step adds the stride to the row.
- R8: `elemBits` is 16 for the half form. Otherwise it is 32 shifted left by sz.
- R9: `elemCount` equals VL divided by `elemBits`.
- R10: A strobe while steps are being issued, including on the last step, is ignored. It does not extend the burst or change the outputs.
- R11: After reset, `stepValid`, `stepDone` and `undefFlag` are 0.
- R12: `idxRegSel` equals 8 plus bits [14:13] of the word currently presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction strobe |
| instWord | input | 32 | Instruction word |
| dblEn | input | 1 | Double-precision form supported |
| halfEn | input | 1 | Half-precision form supported |
| vecLen | input | 12 | Vector length in bits (power of two, 128..2048) |
| idxRegVal | input | 32 | Value of the selected index register |
| idxRegSel | output | 5 | Index register number to read |
| stepValid | output | 1 | A step request is presented |
| stepDone | output | 1 | Last step of the group |
| srcN | output | 5 | First-source register |
| srcM | output | 4 | Second-source register |
| zaRow | output | 8 | Accumulator-array row |
| elemBits | output | 7 | Element width in bits |
| elemCount | output | 8 | Elements per vector |
| undefFlag | output | 1 | Undefined-instruction pulse |

## Verification
The assertions take three things for granted about the inputs. `vecLen` is a power of two from 128 to 2048. It does not change from acceptance until the last step. The index value is valid in the cycle of the strobe. The bench meets these conditions by drawing the vector length as 128 shifted by 0 to 4 and by holding it for the whole burst. The random words are mostly legal encodings with random fields. Some of them have one fixed bit flipped, or the feature enables cleared, so that the undefined path is covered alongside the wrap of the source register and the row arithmetic.

// File: rtl/mvfma_pkg.sv
package mvfma_pkg;
  localparam int WORD_W = 32;
  localparam int VL_W   = 12;
  localparam int ROW_W  = 8;
  localparam int CNT_W  = 8;
  localparam int STEP_W = 2;

  typedef struct packed {
    logic load;
    logic adv;
  } ctrlStrobe_t;
endpackage

// File: rtl/mvfma_ctrl.sv
module mvfma_ctrl
  import mvfma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  logic              dblEn,
  input  logic              halfEn,
  output ctrlStrobe_t       strobe,
  output logic              stepValid,
  output logic              stepDone,
  output logic              undefFlag
);
  logic              active;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W-1:0] lastIdx;
  logic              fixedOk, isHalf, szBit, legal, accept;

  assign szBit   = instWord[22];
  assign isHalf  = instWord[10];
  assign fixedOk = (instWord[31:23] == 9'b110000010) && instWord[21] &&
                   !instWord[15] && (instWord[12:11] == 2'b11) &&
                   (instWord[4:3] == 2'b00);
  assign legal   = fixedOk &&
                   (isHalf ? (halfEn && !szBit) : (!szBit || dblEn));
  assign accept  = instValid && !active;

  assign stepValid   = active;
  assign stepDone    = active && (stepCnt == lastIdx);
  assign strobe.load = accept && legal;
  assign strobe.adv  = active && !stepDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      stepCnt   <= '0;
      lastIdx   <= '0;
      undefFlag <= 1'b0;
    end else begin
      undefFlag <= accept && !legal;
      if (strobe.load) begin
        active  <= 1'b1;
        stepCnt <= '0;
        lastIdx <= instWord[20] ? STEP_W'(3) : STEP_W'(1);
      end else if (stepDone) begin
        active <= 1'b0;
      end else if (active) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  // R1 / R2: undefined pulse lasts a single cycle
  a_r1_undef_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    undefFlag |=> !undefFlag);
  // R1: no step issued alongside an undefined report
  a_r1_undef_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undefFlag, stepValid}));
  // R3: a non-final step is always followed by another step
  a_r3_burst_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && !stepDone) |=> stepValid);
  // R10: after the final step the sequencer is idle for a cycle
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    stepDone |=> !stepValid);
endmodule

// File: rtl/mvfma_dpath.sv
module mvfma_dpath
  import mvfma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] instWord,
  input  logic [VL_W-1:0]   vecLen,
  input  logic [31:0]       idxRegVal,
  output logic [4:0]        srcN,
  output logic [3:0]        srcM,
  output logic [ROW_W-1:0]  zaRow,
  output logic [6:0]        elemBits,
  output logic [CNT_W-1:0]  elemCount
);
  logic [ROW_W-1:0] strideQ, strideNext, rowStart;
  logic [31:0]      idxSum;
  logic [6:0]       bitsNext;
  logic [CNT_W-1:0] cntNext;

  assign strideNext = ROW_W'(vecLen >> (instWord[20] ? 5 : 4));
  assign idxSum     = idxRegVal + {29'd0, instWord[2:0]};
  assign rowStart   = idxSum[ROW_W-1:0] & (strideNext - 1'b1);
  assign bitsNext   = instWord[10] ? 7'd16 : (instWord[22] ? 7'd64 : 7'd32);

  always_comb begin
    case (bitsNext)
      7'd16:   cntNext = CNT_W'(vecLen >> 4);
      7'd32:   cntNext = CNT_W'(vecLen >> 5);
      default: cntNext = CNT_W'(vecLen >> 6);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcN      <= '0;
      srcM      <= '0;
      zaRow     <= '0;
      strideQ   <= '0;
      elemBits  <= '0;
      elemCount <= '0;
    end else if (strobe.load) begin
      srcN      <= instWord[9:5];
      srcM      <= instWord[19:16];
      zaRow     <= rowStart;
      strideQ   <= strideNext;
      elemBits  <= bitsNext;
      elemCount <= cntNext;
    end else if (strobe.adv) begin
      srcN  <= srcN + 1'b1;
      zaRow <= zaRow + strideQ;
    end
  end

  // R9: element count times element width covers the loaded vector length
  a_r9_count_width: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.load) |-> (32'(elemCount) * 32'(elemBits) == 32'($past(vecLen))));
endmodule

// File: rtl/mvfma_issue_seq.sv
module mvfma_issue_seq
  import mvfma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  input  logic              dblEn,
  input  logic              halfEn,
  input  logic [VL_W-1:0]   vecLen,
  input  logic [31:0]       idxRegVal,
  output logic [4:0]        idxRegSel,
  output logic              stepValid,
  output logic              stepDone,
  output logic [4:0]        srcN,
  output logic [3:0]        srcM,
  output logic [ROW_W-1:0]  zaRow,
  output logic [6:0]        elemBits,
  output logic [CNT_W-1:0]  elemCount,
  output logic              undefFlag
);
  ctrlStrobe_t strobe;

  assign idxRegSel = {3'b010, instWord[14:13]};

  mvfma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instWord(instWord),
    .dblEn(dblEn), .halfEn(halfEn), .strobe(strobe),
    .stepValid(stepValid), .stepDone(stepDone), .undefFlag(undefFlag)
  );

  mvfma_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .instWord(instWord),
    .vecLen(vecLen), .idxRegVal(idxRegVal), .srcN(srcN), .srcM(srcM),
    .zaRow(zaRow), .elemBits(elemBits), .elemCount(elemCount)
  );

  // R4: first-source register steps by one with 5-bit wrap
  a_r4_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && !stepDone) |=> (srcN == 5'($past(srcN) + 5'd1)));
  // R5: second-source register is held across the burst
  a_r5_m_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && !stepDone) |=> $stable(srcM));
  // R6: row stays inside the array (vecLen held during a burst)
  a_r6_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    stepValid |-> (12'(zaRow) < (vecLen >> 3)));
  // R7: row increments are equal across a burst
  a_r7_even_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && $past(stepValid) && $past(stepValid, 2) && !$past(stepDone, 2))
    |-> (ROW_W'(zaRow - $past(zaRow)) == ROW_W'($past(zaRow) - $past(zaRow, 2))));
endmodule

// File: tb/tb_mvfma_issue_seq.sv
module tb_mvfma_issue_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        dblEn = 1'b1, halfEn = 1'b1;
  logic [11:0] vecLen = 12'd512;
  logic [31:0] idxRegVal = '0;
  logic [4:0]  idxRegSel, srcN;
  logic        stepValid, stepDone, undefFlag;
  logic [3:0]  srcM;
  logic [7:0]  zaRow, elemCount;
  logic [6:0]  elemBits;
  int checks = 0, fails = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  mvfma_issue_seq dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit sz, input bit four, input bit half,
      input logic [3:0] zm, input logic [1:0] rv, input logic [4:0] zn, input logic [2:0] off);
    return {9'b110000010, sz, 1'b1, four, zm, 1'b0, rv, 2'b11, half, zn, 2'b00, off};
  endfunction

  function automatic bit isLegal(input logic [31:0] w, input bit d, input bit h);
    bit fx = (w[31:23] == 9'b110000010) && w[21] && !w[15] && (w[12:11] == 2'b11) && (w[4:3] == 2'b00);
    return fx && (w[10] ? (h && !w[22]) : (!w[22] || d));
  endfunction

  // Drive one word at a negedge and check the outcome; hitBusy strobes during the burst
  task automatic run(input logic [31:0] w, input logic [31:0] idx, input logic [11:0] vl,
                     input bit d, input bit h, input bit hitBusy);
    int nreg, eb, stride, start;
    bit legal;
    @(negedge clk);
    instWord = w; idxRegVal = idx; vecLen = vl; dblEn = d; halfEn = h; instValid = 1'b1;
    #0.5;
    chk(idxRegSel == 5'(8 + w[14:13]), "R12", idxRegSel, 8 + w[14:13]);
    legal  = isLegal(w, d, h);
    nreg   = w[20] ? 4 : 2;
    eb     = w[10] ? 16 : (w[22] ? 64 : 32);
    stride = (vl / 8) / nreg;
    start  = (32'(idx + 32'(w[2:0]))) % stride;
    @(negedge clk);
    instValid = 1'b0;
    if (!legal) begin
      chk(undefFlag && !stepValid, w[10] || w[22] ? "R2 undef" : "R1 undef", undefFlag, 1);
      @(negedge clk);
      chk(!undefFlag && !stepValid, "R1 pulse end", undefFlag, 0);
      return;
    end
    chk(!undefFlag, "R2 legal", undefFlag, 0);
    for (int r = 0; r < nreg; r++) begin
      if (hitBusy) begin
        instValid = 1'b1;
        instWord  = mk(0, 1, 0, 4'd9, 2'd1, 5'd3, 3'd5);
        idxRegVal = 32'h55;
      end
      chk(stepValid, "R3 valid", stepValid, 1);
      chk(stepDone == (r == nreg - 1), "R3 done", stepDone, r == nreg - 1);
      chk(srcN == 5'(w[9:5] + r), "R4 srcN", srcN, (w[9:5] + r) % 32);
      chk(srcM == w[19:16], "R5 srcM", srcM, w[19:16]);
      chk(int'(zaRow) == start + r * stride, r == 0 ? "R6 row" : "R7 row", zaRow, start + r * stride);
      chk(int'(elemBits) == eb, "R8 bits", elemBits, eb);
      chk(int'(elemCount) == vl / eb, "R9 count", elemCount, vl / eb);
      @(negedge clk);
    end
    instValid = 1'b0;
    chk(!stepValid && !undefFlag, hitBusy ? "R10 ignored" : "R3 end", stepValid, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(!stepValid && !stepDone && !undefFlag, "R11 reset", {stepValid, stepDone, undefFlag}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!stepValid && !undefFlag, "R11 after release", stepValid, 0);
    // directed corners
    run(mk(0, 0, 0, 4'd15, 2'd0, 5'd31, 3'd7), 32'hFFFF_FFFF, 12'd128, 1, 1, 0); // R4 wrap, R6 wrap
    run(mk(1, 1, 0, 4'd0, 2'd3, 5'd30, 3'd3), 32'd13, 12'd2048, 1, 1, 0);
    run(mk(0, 1, 1, 4'd7, 2'd2, 5'd29, 3'd0), 32'd100, 12'd1024, 0, 1, 0);
    run(mk(1, 0, 0, 4'd1, 2'd1, 5'd2, 3'd1), 32'd5, 12'd256, 0, 1, 0);  // R2 no double
    run(mk(0, 0, 1, 4'd1, 2'd1, 5'd2, 3'd1), 32'd5, 12'd256, 1, 0, 0);  // R2 no half
    run(mk(1, 0, 1, 4'd1, 2'd1, 5'd2, 3'd1), 32'd5, 12'd256, 1, 1, 0);  // R2 half with sz
    run(mk(0, 0, 0, 4'd1, 2'd1, 5'd2, 3'd1) ^ 32'h0000_8000, 32'd5, 12'd256, 1, 1, 0); // R1
    run(mk(0, 0, 0, 4'd1, 2'd1, 5'd2, 3'd1) ^ 32'h0000_0010, 32'd5, 12'd256, 1, 1, 0); // R1
    run(mk(0, 1, 0, 4'd4, 2'd0, 5'd10, 3'd2), 32'd77, 12'd512, 1, 1, 1); // R10
    run(mk(0, 0, 0, 4'd4, 2'd0, 5'd10, 3'd2), 32'd77, 12'd512, 1, 1, 1); // R10
    // random
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      w = mk(1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 2'($urandom),
             5'($urandom), 3'($urandom));
      if ($urandom_range(0, 9) == 0) w = w ^ (32'h1 << $urandom_range(21, 31));
      run(w, $urandom, 12'(128 << $urandom_range(0, 4)),
          $urandom_range(0, 4) != 0, $urandom_range(0, 4) != 0, $urandom_range(0, 5) == 0);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule